// File: doc/BRIEF.md
# Instruction Prefix Byte Scanner

The scanner sits at the front of an instruction decoder. It takes one instruction byte per clock, qualified by a valid strobe. It absorbs the leading legacy prefix bytes and sorts each into one of five groups: operand size, address size, segment override, bus lock and string repeat. A second prefix from a group it has already seen in the same instruction sets a violation flag.

The first byte that is not a prefix ends the prefix run. One cycle later the scanner raises a single-cycle done strobe. With it come that byte and a summary of the prefixes. The summary holds the segment override, the lock flag, the repeat kind, both size-override flags and the violation flag.

The scanner also reports the effective operand size. This comes from the operating mode, the code-segment default-size bit and a separately decoded wide-operand flag, all sampled together with the terminating byte. The collected state is then cleared, so the next byte starts a new instruction.

Top module: `prefix_scan`

## Requirements
- R1: With in_valid high, the prefix bytes are 66h (operand-size group), 67h (address-size group), 26h, 2Eh, 36h, 3Eh, 64h and 65h (segment group: ES, CS, SS, DS, FS, GS), F0h (lock group), and F3h and F2h (repeat group). A prefix byte is absorbed without raising done_o. osz_o, asz_o and lock_o are 1 when their prefix was seen.
- R2: When a prefix arrives from a group already seen in the current instruction, viol_o is 1 in the summary that ends the instruction. F2h and F3h count as the same group.
- R3: Within a group the latest prefix wins. The segment code is seg_o (0 none, 1 ES, 2 CS, 3 SS, 4 DS, 5 FS, 6 GS). The repeat code is rep_o (0 none, 1 F3h, 2 F2h).
- R4: In 64-bit mode (mode_i = 2), an ES, CS, SS or DS override is reported as seg_o = 0. An FS or GS override is reported unchanged.
- R5: In 64-bit mode, opsize_o (0 = 16, 1 = 32, 2 = 64 bits) is 2 when rexw_i is 1, whatever the prefixes. Otherwise it is 0 when 66h was seen and 1 when it was not.
- R6: In any other mode (mode_i = 0, 1 or 3), the default size is 32 bits when dbit_i is 1 and 16 bits when dbit_i is 0. A 66h prefix selects the other of the two. opsize_o is never 2 in these modes.
- R7: A valid non-prefix byte accepted at one clock edge makes done_o 1 for exactly the following cycle. In that cycle opcode_o equals the byte. mode_i, dbit_i and rexw_i are sampled at the same edge.
- R8: After done_o, the next instruction starts with no prefix and no violation carried over.
- R9: Synchronous active-high reset clears done_o, every summary output and all collected prefix state.
- R10: A byte presented with in_valid low has no effect, even if its value is a prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_byte carries a byte this cycle |
| in_byte | input | 8 | Instruction byte |
| mode_i | input | 2 | Operating mode: 0 legacy, 1 compatibility, 2 64-bit, 3 as legacy |
| dbit_i | input | 1 | Code-segment default-size bit |
| rexw_i | input | 1 | Wide-operand flag from the separate REX decode |
| done_o | output | 1 | One-cycle strobe: prefix run ended |
| opcode_o | output | 8 | First non-prefix byte |
| seg_o | output | 3 | Effective segment override code |
| lock_o | output | 1 | Lock prefix seen |
| rep_o | output | 2 | Repeat kind |
| osz_o | output | 1 | Operand-size override seen |
| asz_o | output | 1 | Address-size override seen |
| viol_o | output | 1 | A prefix group repeated |
| opsize_o | output | 2 | Effective operand size code |

## Verification
Every result is due exactly one clock after the edge that accepts the terminating byte, because all summary outputs come from one register stage. For a prefix byte, the only due result is that done_o stays low in the following cycle. The bench drives each byte just after a falling edge and samples the outputs at the next falling edge, which puts every sample one full register stage after its stimulus. The cycle after each done_o is also sampled, to confirm the strobe has dropped.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int BYTE_W  = 8;
  localparam int NGRP    = 5;
  localparam int G_OSZ   = 0;
  localparam int G_ASZ   = 1;
  localparam int G_SEG   = 2;
  localparam int G_LOCK  = 3;
  localparam int G_REP   = 4;

  typedef enum logic [2:0] {
    SEG_NONE = 3'd0, SEG_ES = 3'd1, SEG_CS = 3'd2, SEG_SS = 3'd3,
    SEG_DS = 3'd4, SEG_FS = 3'd5, SEG_GS = 3'd6
  } seg_e;

  typedef enum logic [1:0] {REP_NONE = 2'd0, REP_EQ = 2'd1, REP_NE = 2'd2} rep_e;
  typedef enum logic [1:0] {MD_LEGACY = 2'd0, MD_COMPAT = 2'd1, MD_LONG = 2'd2, MD_ALT = 2'd3} mode_e;
  typedef enum logic [1:0] {OPS_16 = 2'd0, OPS_32 = 2'd1, OPS_64 = 2'd2} ops_e;
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output logic              is_pfx,
  output logic [NGRP-1:0]   grp,
  output seg_e              seg,
  output rep_e              rep
);
  always_comb begin
    grp = '0;
    seg = SEG_NONE;
    rep = REP_NONE;
    case (byte_i)
      8'h66: grp[G_OSZ] = 1'b1;
      8'h67: grp[G_ASZ] = 1'b1;
      8'h26: begin grp[G_SEG] = 1'b1; seg = SEG_ES; end
      8'h2E: begin grp[G_SEG] = 1'b1; seg = SEG_CS; end
      8'h36: begin grp[G_SEG] = 1'b1; seg = SEG_SS; end
      8'h3E: begin grp[G_SEG] = 1'b1; seg = SEG_DS; end
      8'h64: begin grp[G_SEG] = 1'b1; seg = SEG_FS; end
      8'h65: begin grp[G_SEG] = 1'b1; seg = SEG_GS; end
      8'hF0: grp[G_LOCK] = 1'b1;
      8'hF3: begin grp[G_REP] = 1'b1; rep = REP_EQ; end
      8'hF2: begin grp[G_REP] = 1'b1; rep = REP_NE; end
      default: ;
    endcase
    is_pfx = |grp;
  end
endmodule

// File: rtl/pfx_accum.sv
module pfx_accum
  import pfx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            clear,
  input  logic [NGRP-1:0] grp,
  input  seg_e            seg_in,
  input  rep_e            rep_in,
  output logic [NGRP-1:0] seen,
  output logic            viol_q,
  output seg_e            seg_q,
  output rep_e            rep_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen   <= '0;
      viol_q <= 1'b0;
      seg_q  <= SEG_NONE;
      rep_q  <= REP_NONE;
    end else if (take) begin
      seen <= seen | grp;
      if (|(seen & grp)) viol_q <= 1'b1;
      if (grp[G_SEG]) seg_q <= seg_in;
      if (grp[G_REP]) rep_q <= rep_in;
    end
  end

  // R2: a repeated group marks the instruction as violating
  a_r2_dup_flagged: assert property (@(posedge clk) disable iff (rst)
    (take && !clear && |(seen & grp)) |=> viol_q);

  // R8: the terminating byte leaves no collected state behind
  a_r8_clean_after_end: assert property (@(posedge clk) disable iff (rst)
    clear |=> (seen == '0) && !viol_q);
endmodule

// File: rtl/pfx_opsize.sv
module pfx_opsize
  import pfx_pkg::*;
(
  input  mode_e mode,
  input  logic  dbit,
  input  logic  rexw,
  input  logic  osz,
  output ops_e  size
);
  always_comb begin
    if (mode == MD_LONG) begin
      if (rexw)     size = OPS_64;
      else if (osz) size = OPS_16;
      else          size = OPS_32;
    end else begin
      size = (dbit ^ osz) ? OPS_32 : OPS_16;
    end
  end
endmodule

// File: rtl/prefix_scan.sv
module prefix_scan
  import pfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic [1:0] mode_i,
  input  logic       dbit_i,
  input  logic       rexw_i,
  output logic       done_o,
  output logic [7:0] opcode_o,
  output logic [2:0] seg_o,
  output logic       lock_o,
  output logic [1:0] rep_o,
  output logic       osz_o,
  output logic       asz_o,
  output logic       viol_o,
  output logic [1:0] opsize_o
);
  logic            is_pfx;
  logic [NGRP-1:0] grp;
  seg_e            seg_c;
  rep_e            rep_c;
  logic [NGRP-1:0] seen;
  logic            viol_q;
  seg_e            seg_q;
  rep_e            rep_q;
  logic            take, ends;
  mode_e           mode;
  seg_e            seg_eff;
  ops_e            size_c;

  assign take = in_valid && is_pfx;
  assign ends = in_valid && !is_pfx;
  assign mode = mode_e'(mode_i);

  pfx_classify u_cls (.byte_i(in_byte), .is_pfx(is_pfx), .grp(grp), .seg(seg_c), .rep(rep_c));

  pfx_accum u_acc (
    .clk(clk), .rst(rst), .take(take), .clear(ends), .grp(grp),
    .seg_in(seg_c), .rep_in(rep_c), .seen(seen), .viol_q(viol_q),
    .seg_q(seg_q), .rep_q(rep_q)
  );

  pfx_opsize u_ops (.mode(mode), .dbit(dbit_i), .rexw(rexw_i), .osz(seen[G_OSZ]), .size(size_c));

  always_comb begin
    seg_eff = seg_q;
    if (mode == MD_LONG && seg_q != SEG_FS && seg_q != SEG_GS) seg_eff = SEG_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      opcode_o <= '0;
      seg_o    <= '0;
      lock_o   <= 1'b0;
      rep_o    <= '0;
      osz_o    <= 1'b0;
      asz_o    <= 1'b0;
      viol_o   <= 1'b0;
      opsize_o <= '0;
    end else begin
      done_o <= ends;
      if (ends) begin
        opcode_o <= in_byte;
        seg_o    <= seg_eff;
        lock_o   <= seen[G_LOCK];
        rep_o    <= rep_q;
        osz_o    <= seen[G_OSZ];
        asz_o    <= seen[G_ASZ];
        viol_o   <= viol_q;
        opsize_o <= size_c;
      end
    end
  end

  // R7: a strobe only follows an accepted byte
  a_r7_done_after_valid: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(in_valid));
  // R4: in 64-bit mode only FS or GS survive
  a_r4_seg_long: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(mode_i) == 2'd2) |-> (seg_o == 3'd0 || seg_o == 3'd5 || seg_o == 3'd6));
  // R5: wide flag forces 64 bits in 64-bit mode
  a_r5_wide: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(mode_i) == 2'd2 && $past(rexw_i)) |-> opsize_o == 2'd2);
  // R6: outside 64-bit mode the size is never 64
  a_r6_no_wide: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(mode_i) != 2'd2) |-> opsize_o != 2'd2);
  // R9: the first cycle after reset carries no strobe
  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !done_o);
endmodule

// File: tb/test_prefix_scan.sv
module test_prefix_scan;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, dbit_i = 1'b0, rexw_i = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [1:0] mode_i = 2'd0;
  logic done_o, lock_o, osz_o, asz_o, viol_o;
  logic [7:0] opcode_o;
  logic [2:0] seg_o;
  logic [1:0] rep_o, opsize_o;
  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] pf [0:5];
  int npf;

  always #2 clk = ~clk;

  prefix_scan i_prefix_scan (.clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .mode_i(mode_i), .dbit_i(dbit_i), .rexw_i(rexw_i), .done_o(done_o), .opcode_o(opcode_o),
    .seg_o(seg_o), .lock_o(lock_o), .rep_o(rep_o), .osz_o(osz_o), .asz_o(asz_o),
    .viol_o(viol_o), .opsize_o(opsize_o));

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int grp_of(logic [7:0] b);
    case (b)
      8'h66: return 0; 8'h67: return 1;
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: return 2;
      8'hF0: return 3; 8'hF3, 8'hF2: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic int seg_code(logic [7:0] b);
    case (b)
      8'h26: return 1; 8'h2E: return 2; 8'h36: return 3;
      8'h3E: return 4; 8'h64: return 5; 8'h65: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] rand_pfx();
    case ($urandom_range(0, 10))
      0: return 8'h66; 1: return 8'h67; 2: return 8'h26; 3: return 8'h2E;
      4: return 8'h36; 5: return 8'h3E; 6: return 8'h64; 7: return 8'h65;
      8: return 8'hF0; 9: return 8'hF3; default: return 8'hF2;
    endcase
  endfunction

  function automatic logic [7:0] rand_op();
    logic [7:0] b;
    do b = 8'($urandom); while (grp_of(b) >= 0);
    return b;
  endfunction

  // drive after a falling edge, return at the next falling edge
  task automatic cyc(logic v, logic [7:0] b);
    in_valid = v; in_byte = b;
    @(negedge clk);
  endtask

  task automatic run_insn(logic [7:0] op, int md, logic d, logic w, bit gaps);
    int seen [0:4];
    int eseg = 0, erep = 0, eviol = 0, eops;
    for (int g = 0; g < 5; g++) seen[g] = 0;
    for (int i = 0; i < npf; i++) begin
      int g = grp_of(pf[i]);
      if (gaps && $urandom_range(0, 2) == 0) begin
        cyc(1'b0, rand_pfx());
        chk("R10", "done on idle byte", done_o, 0);
      end
      cyc(1'b1, pf[i]);
      chk("R1", "done on prefix", done_o, 0);
      if (seen[g] != 0) eviol = 1;
      seen[g] = 1;
      if (g == 2) eseg = seg_code(pf[i]);
      if (g == 4) erep = (pf[i] == 8'hF3) ? 1 : 2;
    end
    if (md == 2 && eseg != 5 && eseg != 6) eseg = 0;
    if (md == 2) eops = w ? 2 : (seen[0] != 0 ? 0 : 1);
    else eops = ((d ^ (seen[0] != 0)) != 0) ? 1 : 0;
    mode_i = 2'(md); dbit_i = d; rexw_i = w;
    cyc(1'b1, op);
    chk("R7", "done strobe", done_o, 1);
    chk("R7", "opcode", opcode_o, op);
    chk("R1", "osz", osz_o, seen[0]);
    chk("R1", "asz", asz_o, seen[1]);
    chk("R1", "lock", lock_o, seen[3]);
    chk("R3/R4", "seg", seg_o, eseg);
    chk("R3", "rep", rep_o, erep);
    chk("R2", "viol", viol_o, eviol);
    chk(md == 2 ? "R5" : "R6", "opsize", opsize_o, eops);
    mode_i = 2'($urandom); dbit_i = 1'($urandom); rexw_i = 1'($urandom);
    cyc(1'b0, 8'h00);
    chk("R7", "strobe width", done_o, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R9", "done in reset", done_o, 0);
    rst = 1'b0;
    cyc(1'b0, 8'h00);
    chk("R9", "done after reset", done_o, 0);
    chk("R9", "viol after reset", viol_o, 0);
    chk("R9", "seg after reset", seg_o, 0);
    // R4: CS dropped in 64-bit mode, kept in compatibility mode
    npf = 1; pf[0] = 8'h2E; run_insn(8'h8B, 2, 1'b0, 1'b0, 0);
    npf = 1; pf[0] = 8'h2E; run_insn(8'h8B, 1, 1'b1, 1'b0, 0);
    // R4: GS kept in 64-bit mode; R5 wide wins over 66h
    npf = 2; pf[0] = 8'h66; pf[1] = 8'h65; run_insn(8'h89, 2, 1'b0, 1'b1, 0);
    // R2/R3: F3 then F2 -> violation, F2 kept
    npf = 2; pf[0] = 8'hF3; pf[1] = 8'hF2; run_insn(8'hA4, 0, 1'b0, 1'b0, 0);
    // R8: next instruction is clean
    npf = 0; run_insn(8'h90, 0, 1'b0, 1'b0, 0);
    // R3: two segment overrides, last kept, flagged
    npf = 2; pf[0] = 8'h26; pf[1] = 8'h36; run_insn(8'h8A, 0, 1'b1, 1'b0, 0);
    // R10: an invalid 66h does not count
    cyc(1'b0, 8'h66);
    chk("R10", "done on invalid", done_o, 0);
    npf = 0; run_insn(8'h01, 0, 1'b0, 1'b0, 0);
    // R6: legacy 16-bit default with 66h -> 32
    npf = 1; pf[0] = 8'h66; run_insn(8'h01, 3, 1'b0, 1'b1, 0);
    // R9: reset mid-prefix clears state
    cyc(1'b1, 8'hF0);
    rst = 1'b1; cyc(1'b0, 8'h00); rst = 1'b0;
    npf = 0; run_insn(8'h02, 0, 1'b1, 1'b0, 0);
    for (int n = 0; n < 400; n++) begin
      npf = $urandom_range(0, 5);
      for (int i = 0; i < npf; i++) pf[i] = rand_pfx();
      run_insn(rand_op(), $urandom_range(0, 3), 1'($urandom), 1'($urandom), 1);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule